// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A front end presents a fetch address on the lookup port and receives a taken/not-taken guess in the same cycle. When the branch later executes, the back end presents the branch address and its real outcome on the resolve port. In that cycle the block reports whether its guess for that address was wrong. At the clock edge that ends the cycle, it trains its table.

A two-bit mode input picks one of three schemes. The simplest stores only the last outcome seen for each table slot. The second keeps a two-bit counter that moves up or down and saturates at both ends. The third keeps a single global history bit holding the most recent resolved outcome. It joins that bit with low address bits, so each branch gets two one-bit slots, one for each value of the preceding outcome. Changing the mode wipes all learned state, so no scheme ever inherits entries written by another.

Top module: `branch_dir_pred`

## Requirements
- R1: After reset every table slot reads not-taken, the history bit is 0, and `predTaken` is 0 for every lookup address while `mode` is held at 2'b00.
- R2: Mode encoding: 2'b00 selects last-outcome, 2'b01 selects the saturating counter, 2'b10 selects two-level history, and 2'b11 behaves exactly like 2'b00.
- R3: In last-outcome mode a resolve stores the outcome as the slot's single bit, and the guess is taken exactly when that bit is 1.
- R4: In counter mode a taken outcome increments the slot and a not-taken outcome decrements it. The counter holds at 3 on taken and at 0 on not-taken, and the guess is taken when the counter is 2 or 3.
- R5: In two-level mode the slot index is {history, pc[4:2]} with the history bit as the MSB. The history bit takes the outcome of every accepted resolve, in every mode.
- R6: In last-outcome and counter modes the slot index is pc[5:2].
- R7: `mispredict` is high, combinationally, in a cycle with `resolveValid` high when the guess read for `resolvePc` differs from `resolveTaken`. The slot is written at the edge that closes that cycle, so a lookup of the same slot in that cycle still sees the old value.
- R8: In any cycle where `mode` differs from its value in the previous cycle, `predTaken` and `mispredict` are 0 and any resolve is dropped. All slots and the history bit return to their reset values at that edge.
- R9: For the outcome run N,T,N,N,T,T,T,N on one branch, starting from a cleared table, the wrong guesses fall on the following branches (1-based):
  - last-outcome: branches 2, 3, 5 and 8;
  - counter: branches 2, 5, 6 and 8;
  - two-level: branches 2, 4, 5, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Scheme select (see R2) |
| lookupPc | input | PC_W | Fetch address to predict |
| predTaken | output | 1 | Guess for `lookupPc` |
| resolveValid | input | 1 | A branch outcome is presented this cycle |
| resolvePc | input | PC_W | Address of the resolving branch |
| resolveTaken | input | 1 | Real outcome of the resolving branch |
| mispredict | output | 1 | Guess for `resolvePc` was wrong this cycle |

## Verification
The assertions watch the per-edge training rules on every cycle:
- the single-bit write in the one-bit schemes;
- the counter holding at both ends;
- the history bit taking the last outcome;
- a mode change wiping the history and leaving the next guess not-taken.

The per-scheme misprediction patterns, the index formation of each mode, and the aliasing of mode 2'b11 can only be shown by the bench's scenarios:
- the directed outcome run;
- trained slots that go dark after a mode switch;
- long random traffic compared against an independent model.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    SCHEME_LAST = 2'd0,
    SCHEME_SAT  = 2'd1,
    SCHEME_HIST = 2'd2
  } scheme_e;

  // strobes from control to datapath
  typedef struct packed {
    scheme_e scheme;
    logic    clearAll;
    logic    writeEn;
  } ctrl_strobe_t;

  function automatic scheme_e decodeMode(input logic [1:0] m);
    case (m)
      2'b01:   return SCHEME_SAT;
      2'b10:   return SCHEME_HIST;
      default: return SCHEME_LAST;
    endcase
  endfunction

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic taken);
    if (taken) return (cur == 2'b11) ? cur : cur + 2'd1;
    else       return (cur == 2'b00) ? cur : cur - 2'd1;
  endfunction

endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic         resolveValid,
  input  logic         resolveTaken,
  input  logic         resolvePred,
  output ctrl_strobe_t strobe,
  output logic         mispredict
);

  logic [1:0] prevMode;
  logic       modeChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMode <= 2'b00;
    else       prevMode <= mode;
  end

  assign modeChange = (mode != prevMode);

  always_comb begin
    strobe.scheme   = decodeMode(mode);
    strobe.clearAll = modeChange;
    strobe.writeEn  = resolveValid && !modeChange;
  end

  assign mispredict = strobe.writeEn && (resolvePred != resolveTaken);

  // R8: a changed mode input must reach the datapath as a clear on the next edge's evaluation
  p_mode_switch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (prevMode != $past(prevMode)) |-> $past(strobe.clearAll));

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strobe_t    strobe,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  output logic            predTaken,
  output logic            resolvePred
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int LOW_W   = IDX_W - 1;
  localparam int PC_LSB  = 2;

  logic [1:0]       tbl [ENTRIES];
  logic             hist;
  logic [IDX_W-1:0] lookupIdx, resIdx;
  logic [1:0]       lookupEntry, resEntry, nextEntry;
  logic [ENTRIES-1:0] hitVec;

  function automatic logic [IDX_W-1:0] formIndex(input logic [PC_W-1:0] pc,
                                                 input scheme_e sch,
                                                 input logic h);
    if (sch == SCHEME_HIST) return {h, pc[PC_LSB +: LOW_W]};
    else                    return pc[PC_LSB +: IDX_W];
  endfunction

  function automatic logic guessOf(input logic [1:0] e, input scheme_e sch);
    return (sch == SCHEME_SAT) ? e[1] : e[0];
  endfunction

  assign lookupIdx   = formIndex(lookupPc, strobe.scheme, hist);
  assign resIdx      = formIndex(resolvePc, strobe.scheme, hist);
  assign lookupEntry = tbl[lookupIdx];
  assign resEntry    = tbl[resIdx];

  always_comb begin
    if (strobe.scheme == SCHEME_SAT) nextEntry = satStep(resEntry, resolveTaken);
    else                             nextEntry = {1'b0, resolveTaken};
  end

  assign predTaken   = !strobe.clearAll && guessOf(lookupEntry, strobe.scheme);
  assign resolvePred = guessOf(resEntry, strobe.scheme);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_hit
      assign hitVec[g] = strobe.writeEn && (resIdx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 2'b00;
    end else if (strobe.clearAll) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 2'b00;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (hitVec[i]) tbl[i] <= nextEntry;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hist <= 1'b0;
    else if (strobe.clearAll) hist <= 1'b0;
    else if (strobe.writeEn)  hist <= resolveTaken;
  end

  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |=> (hist == $past(resolveTaken)));

  p_clear_hist_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (hist == 1'b0));

  p_clear_guess_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> !predTaken);

  p_one_bit_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && strobe.scheme != SCHEME_SAT)
      |=> (tbl[$past(resIdx)] == {1'b0, $past(resolveTaken)}));

  p_sat_ceiling_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && strobe.scheme == SCHEME_SAT && resEntry == 2'b11 && resolveTaken)
      |=> (tbl[$past(resIdx)] == 2'b11));

  p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && strobe.scheme == SCHEME_SAT && resEntry == 2'b00 && !resolveTaken)
      |=> (tbl[$past(resIdx)] == 2'b00));

endmodule

// File: rtl/branch_dir_pred.sv
module branch_dir_pred
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      mode,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  output logic            mispredict
);

  ctrl_strobe_t strobe;
  logic         resolvePred;

  bp_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (mode),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .resolvePred  (resolvePred),
    .strobe       (strobe),
    .mispredict   (mispredict)
  );

  bp_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lookupPc     (lookupPc),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken),
    .predTaken    (predTaken),
    .resolvePred  (resolvePred)
  );

  p_misp_needs_resolve_r7: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> resolveValid);

endmodule

// File: tb/branch_dir_pred_tb.sv
`timescale 1ns/1ps
module branch_dir_pred_tb;

  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic [PC_W-1:0] lookupPc = '0;
  logic            predTaken;
  logic            resolveValid = 1'b0;
  logic [PC_W-1:0] resolvePc = '0;
  logic            resolveTaken = 1'b0;
  logic            mispredict;

  int checks = 0;
  int fails  = 0;

  branch_dir_pred #(.PC_W(PC_W), .IDX_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .lookupPc(lookupPc), .predTaken(predTaken),
    .resolveValid(resolveValid), .resolvePc(resolvePc), .resolveTaken(resolveTaken),
    .mispredict(mispredict)
  );

  always #2.5 clk = ~clk;

  // independent reference model
  int   mTbl [16];
  bit   mHist;
  logic [1:0] mPrev;

  function automatic int mIdx(input logic [PC_W-1:0] pc, input logic [1:0] m);
    if (m == 2'b10) return (int'(mHist) << 3) | int'(pc[4:2]);
    return int'(pc[5:2]);
  endfunction

  function automatic bit mGuess(input logic [PC_W-1:0] pc, input logic [1:0] m);
    int v = mTbl[mIdx(pc, m)];
    if (m == 2'b01) return v >= 2;
    return v == 1;
  endfunction

  function automatic void mClear();
    for (int i = 0; i < 16; i++) mTbl[i] = 0;
    mHist = 1'b0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle of traffic; returns sampled mispredict
  task automatic step(input logic [1:0] m, input logic [PC_W-1:0] lpc, input bit rv,
                      input logic [PC_W-1:0] rpc, input bit rt, input string tag,
                      output logic mispOut);
    bit chg, expP, expM;
    int idx;
    @(negedge clk);
    mode = m; lookupPc = lpc; resolveValid = rv; resolvePc = rpc; resolveTaken = rt;
    #1;
    chg  = (m != mPrev);
    expP = chg ? 1'b0 : mGuess(lpc, m);
    expM = (rv && !chg) ? (mGuess(rpc, m) != rt) : 1'b0;
    chk({tag, " predTaken"}, predTaken, expP);
    chk({tag, " mispredict"}, mispredict, expM);
    mispOut = mispredict;
    if (chg) mClear();
    else if (rv) begin
      idx = mIdx(rpc, m);
      if (m == 2'b01) mTbl[idx] = rt ? ((mTbl[idx] == 3) ? 3 : mTbl[idx] + 1)
                                     : ((mTbl[idx] == 0) ? 0 : mTbl[idx] - 1);
      else            mTbl[idx] = rt ? 1 : 0;
      mHist = rt;
    end
    mPrev = m;
  endtask

  // R9 directed run on one branch
  task automatic directedRun(input logic [1:0] m, input bit [7:0] expMiss, input string tag);
    bit [7:0] seq = 8'b0111_0010; // bit i = outcome of branch i+1: N,T,N,N,T,T,T,N
    logic mp;
    logic [1:0] other = (m == 2'b00) ? 2'b01 : 2'b00;
    step(other, '0, 1'b0, '0, 1'b0, {tag, " setup"}, mp);
    step(m, '0, 1'b0, '0, 1'b0, {tag, " switch"}, mp);
    for (int i = 0; i < 8; i++) begin
      step(m, 32'h40, 1'b1, 32'h40, seq[i], tag, mp);
      chk({tag, " run pattern"}, mp, expMiss[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic mp;
    void'($urandom(32'd2024));
    mClear();
    mPrev = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, all slots not-taken
    for (int i = 0; i < 16; i++) begin
      step(2'b00, PC_W'(i * 4), 1'b0, '0, 1'b0, "R1 reset", mp);
      chk("R1 reset guess", predTaken, 1'b0);
    end

    // R9 directed runs (bit i = branch i+1 mispredicted)
    directedRun(2'b00, 8'b1001_0110, "R9 R3 last-outcome");
    directedRun(2'b01, 8'b1011_0010, "R9 R4 counter");
    directedRun(2'b10, 8'b1011_1010, "R9 R5 two-level");
    directedRun(2'b11, 8'b1001_0110, "R9 R2 alias 11");

    // R4 saturation: five taken then one not-taken still predicts taken
    step(2'b00, '0, 1'b0, '0, 1'b0, "R4 setup", mp);
    step(2'b01, '0, 1'b0, '0, 1'b0, "R4 setup", mp);
    for (int i = 0; i < 5; i++) step(2'b01, 32'h10, 1'b1, 32'h10, 1'b1, "R4 up", mp);
    step(2'b01, 32'h10, 1'b1, 32'h10, 1'b0, "R4 down", mp);
    step(2'b01, 32'h10, 1'b0, '0, 1'b0, "R4 hold", mp);
    chk("R4 counter after saturation", predTaken, 1'b1);

    // R6: address bit 6 aliases, bit 2 does not
    step(2'b01, 32'h50, 1'b0, '0, 1'b0, "R6 alias", mp);
    chk("R6 pc[6] aliases to same slot", predTaken, 1'b1);
    step(2'b01, 32'h14, 1'b0, '0, 1'b0, "R6 separate", mp);
    chk("R6 neighbouring slot untouched", predTaken, 1'b0);

    // R7: same-cycle lookup sees old value
    step(2'b01, 32'h20, 1'b1, 32'h20, 1'b1, "R7 same-slot", mp);
    chk("R7 mispredict on first taken", mp, 1'b1);
    step(2'b01, 32'h20, 1'b1, 32'h20, 1'b1, "R7 same-slot", mp);
    chk("R7 lookup reads pre-update counter", predTaken, 1'b0);
    step(2'b01, 32'h20, 1'b0, '0, 1'b0, "R7 after", mp);
    chk("R7 counter trained to 2", predTaken, 1'b1);

    // R8: mode change wipes trained slot and drops resolve
    step(2'b00, '0, 1'b0, '0, 1'b0, "R8 to last", mp);
    step(2'b00, 32'h30, 1'b1, 32'h30, 1'b1, "R8 train", mp);
    step(2'b11, 32'h30, 1'b1, 32'h34, 1'b1, "R8 switch", mp);
    chk("R8 no mispredict in switch cycle", mp, 1'b0);
    step(2'b11, 32'h30, 1'b0, '0, 1'b0, "R8 after", mp);
    chk("R8 trained slot cleared", predTaken, 1'b0);
    step(2'b11, 32'h34, 1'b0, '0, 1'b0, "R8 dropped", mp);
    chk("R8 resolve in switch cycle dropped", predTaken, 1'b0);

    // random traffic, mixed modes, R2..R8 against the model
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] m = mPrev;
      if (($urandom % 64) == 0) m = 2'($urandom % 4);
      step(m, PC_W'(($urandom % 32) * 4), 1'($urandom % 4 != 0),
           PC_W'(($urandom % 32) * 4), 1'($urandom % 3 != 0), "R2-R8 random", mp);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule